// File: doc/BRIEF.md
# DSP Memory Read Engine with Host Read FIFO

This block lets a host processor pull 16-bit words out of a DSP's memory spaces without stalling. The host loads a 16-bit start address and writes a control word. That word selects the memory space, the burst size (one word, eight words, sixteen words or continuous), whether the address advances per word, and the interrupt enables. Setting the go bit starts the transfer. The engine then places read requests on a request/grant port toward the DSP memory and collects the in-order read responses into a 16-entry FIFO. The host drains the FIFO through a data register.

The engine counts the requests that are still in flight. It issues a new request only when the words already held plus the words still due leave room in the FIFO, so a response can never be lost. In continuous mode it refills the FIFO as the host drains it, and it runs until the host clears the go bit or sets the DSP-reset bit. Either action flushes the FIFO. Any responses still in flight are then discarded.

The same control word carries a DSP-reset bit. The block turns it into a reset output with a guaranteed minimum pulse width.

Top module: `dspmem_rd_engine`

## Requirements
- R1: After the synchronous reset, the address, control and status registers read 0, and `irq_o`, `mem_req_o` and `dsp_reset_o` are 0.
- R2: Control bits [3:2] set the burst size: 0 fetches 1 word, 1 fetches 8 words and 2 fetches 16 words. When the last word of the burst is in the FIFO, status bit 0 (transfer active) returns to 0.
- R3: When control bit 1 is 1, the address register advances by one for each accepted request, and the host reads back the advanced value. When bit 1 is 0, every request uses the same address. Host writes to the address register are ignored while status bit 0 is 1.
- R4: Every request carries the address register on `mem_addr_o` and control bits [15:12], as captured when the transfer started, on `mem_space_o`. A request that is not granted holds its address and space until it is granted.
- R5: The FIFO returns words in the order they were fetched. Status bit 5 reads 1 when 16 words are held, and status bit 6 reads 1 when at least one word is held. A data-register read (select 3) on an empty FIFO returns 0 and changes nothing.
- R6: A request is raised only while the words held plus the responses in flight are fewer than 16. In continuous mode (bits [3:2]=3), the engine stops requesting when the FIFO is full and resumes when the host drains it.
- R7: A control write with bit 4 equal to 0 during a transfer ends the transfer and clears status bit 0, and the FIFO is empty from the next cycle. Responses to requests still in flight are discarded.
- R8: `irq_o` equals (control bit 5 AND FIFO full) OR (control bit 6 AND FIFO not empty), registered one cycle after the status.
- R9: Control bit 0 drives `dsp_reset_o` for as many cycles as the bit is held, but never fewer than RST_HOLD (8) cycles. Status bit 2 mirrors `dsp_reset_o`. A control write that sets bit 0 also ends any running transfer, as in R7.
- R10: A control write with bit 4 set while a transfer is active, or while stale responses are draining, does not restart, lengthen or retarget the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe |
| host_sel_i | input | 2 | Register select: 0 address, 1 control, 2 status, 3 data |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Level interrupt to the host |
| dsp_reset_o | output | 1 | Reset toward the DSP |
| mem_req_o | output | 1 | Read request toward DSP memory |
| mem_addr_o | output | ADDR_W | Request word address |
| mem_space_o | output | 4 | Request memory-space code |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read response valid (in request order) |
| mem_rdata_i | input | 16 | Read response word |

## Verification
The hardest situation to reach is a continuous-mode transfer that is full, throttled and then aborted while responses are still in flight. Reaching it needs a memory model with real latency, which the bench provides with a two-stage response pipeline. The bench lets the FIFO fill, drains only part of it so that new requests go out, and then clears the go bit at once so that late responses arrive after the abort. A separate scenario holds the grant low at the start of a burst, then rewrites the address and go bit while the request waits. This shows that an active transfer cannot be disturbed.

// File: rtl/dre_pkg.sv
package dre_pkg;

  localparam int REG_W   = 16;
  localparam int SPACE_W = 4;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } eng_state_e;

  // control word bit positions
  localparam int CB_RST      = 0;
  localparam int CB_AUTO     = 1;
  localparam int CB_LEN_LO   = 2;
  localparam int CB_START    = 4;
  localparam int CB_IE_FULL  = 5;
  localparam int CB_IE_NE    = 6;
  localparam int CB_SPACE_LO = 12;

  // status word bit positions
  localparam int SB_UNDERWAY = 0;
  localparam int SB_RST_BUSY = 2;
  localparam int SB_FULL     = 5;
  localparam int SB_NE       = 6;

  localparam logic [1:0] LEN_FREE = 2'd3;

  typedef struct packed {
    logic [SPACE_W-1:0] space;
    logic               ie_ne;
    logic               ie_full;
    logic [1:0]         len;
    logic               autoinc;
    logic               hold_rst;
  } cfg_t;

  function automatic logic [4:0] burst_words(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd8;
      2'd2:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/dre_regs.sv
module dre_regs
  import dre_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RST_HOLD = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  cfg_t              cfg_wval,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wval,
  input  logic              addr_lock,
  input  logic              addr_inc,
  output cfg_t              cfg,
  output logic [ADDR_W-1:0] addr,
  output logic              dsp_rst
);

  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic [HOLD_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (cfg_we) begin
      cfg <= cfg_wval;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (addr_we && !addr_lock) begin
      addr <= addr_wval;
    end else if (addr_inc) begin
      addr <= addr + ADDR_W'(1);
    end
  end

  // reset pulse stretcher: output follows the bit but lasts RST_HOLD cycles minimum
  always_ff @(posedge clk) begin
    if (rst) begin
      dsp_rst  <= 1'b0;
      hold_cnt <= '0;
    end else if (cfg.hold_rst) begin
      dsp_rst <= 1'b1;
      if (hold_cnt < HOLD_W'(RST_HOLD)) hold_cnt <= hold_cnt + HOLD_W'(1);
    end else if (dsp_rst && hold_cnt < HOLD_W'(RST_HOLD)) begin
      hold_cnt <= hold_cnt + HOLD_W'(1);
    end else begin
      dsp_rst  <= 1'b0;
      hold_cnt <= '0;
    end
  end

endmodule

// File: rtl/dre_fifo.sv
module dre_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_push, do_pop;

  assign do_push = push && (count != CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // storage and output register without reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= din;
    if (pop) dout <= do_pop ? mem[rptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/dre_ctrl.sv
module dre_ctrl
  import dre_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       stop,
  input  logic [1:0]                 len,
  input  logic                       autoinc,
  input  logic [SPACE_W-1:0]         space_in,
  input  logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input  logic                       mem_gnt,
  input  logic                       mem_rvalid,
  output logic                       mem_req,
  output logic [SPACE_W-1:0]         mem_space,
  output logic                       push,
  output logic                       flush,
  output logic                       addr_inc,
  output logic                       underway
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SUM_W = CNT_W + 1;

  eng_state_e         state;
  logic [4:0]         left_q;
  logic [CNT_W-1:0]   out_q;
  logic               free_q, auto_q;
  logic [SPACE_W-1:0] space_q;
  logic               credit, want, accept;

  assign credit   = ({1'b0, fifo_count} + {1'b0, out_q}) < SUM_W'(DEPTH);
  assign want     = free_q || (left_q != '0);
  assign mem_req  = (state == ST_RUN) && want && credit;
  assign accept   = mem_req && mem_gnt;
  assign push     = mem_rvalid && (state == ST_RUN);
  assign flush    = stop && (state == ST_RUN);
  assign addr_inc = accept && auto_q;
  assign underway = (state == ST_RUN);
  assign mem_space = space_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else begin
      case ({accept, mem_rvalid})
        2'b10:   out_q <= out_q + CNT_W'(1);
        2'b01:   out_q <= out_q - CNT_W'(1);
        default: out_q <= out_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      left_q  <= '0;
      free_q  <= 1'b0;
      auto_q  <= 1'b0;
      space_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            left_q  <= burst_words(len);
            free_q  <= (len == LEN_FREE);
            auto_q  <= autoinc;
            space_q <= space_in;
          end
        end
        ST_RUN: begin
          if (stop) begin
            state <= ST_DRAIN;
          end else begin
            if (accept && !free_q) left_q <= left_q - 5'd1;
            if (!free_q && left_q == '0 && out_q == '0) state <= ST_IDLE;
          end
        end
        ST_DRAIN: begin
          if (out_q == '0) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dspmem_rd_engine.sv
module dspmem_rd_engine
  import dre_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DEPTH    = 16,
  parameter int RST_HOLD = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_i,
  input  logic               host_rd_i,
  input  logic [1:0]         host_sel_i,
  input  logic [REG_W-1:0]   host_wdata_i,
  output logic [REG_W-1:0]   host_rdata_o,
  output logic               irq_o,
  output logic               dsp_reset_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [SPACE_W-1:0] mem_space_o,
  input  logic               mem_gnt_i,
  input  logic               mem_rvalid_i,
  input  logic [REG_W-1:0]   mem_rdata_i
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  reg_sel_e         sel, sel_q;
  cfg_t             cfg, cfg_wval;
  logic             cfg_we, addr_we, eng_start, eng_stop;
  logic             fifo_push, fifo_flush, fifo_pop, fifo_full, fifo_ne;
  logic [CNT_W-1:0] fifo_count;
  logic [REG_W-1:0] fifo_dout, rdata_q, status_w, cfg_rb;
  logic             eng_underway, addr_inc;
  logic [ADDR_W-1:0] addr_q;
  logic             unused_wbits;

  assign sel          = reg_sel_e'(host_sel_i);
  assign cfg_we       = host_wr_i && (sel == SEL_CFG);
  assign addr_we      = host_wr_i && (sel == SEL_ADDR);
  assign eng_start    = cfg_we && host_wdata_i[CB_START] && !host_wdata_i[CB_RST];
  assign eng_stop     = cfg_we && (!host_wdata_i[CB_START] || host_wdata_i[CB_RST]);
  assign fifo_pop     = host_rd_i && (sel == SEL_DATA);
  assign unused_wbits = ^host_wdata_i[11:7];

  always_comb begin
    cfg_wval          = '0;
    cfg_wval.hold_rst = host_wdata_i[CB_RST];
    cfg_wval.autoinc  = host_wdata_i[CB_AUTO];
    cfg_wval.len      = host_wdata_i[CB_LEN_LO +: 2];
    cfg_wval.ie_full  = host_wdata_i[CB_IE_FULL];
    cfg_wval.ie_ne    = host_wdata_i[CB_IE_NE];
    cfg_wval.space    = host_wdata_i[CB_SPACE_LO +: SPACE_W];
  end

  dre_regs #(.ADDR_W(ADDR_W), .RST_HOLD(RST_HOLD)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wval  (cfg_wval),
    .addr_we   (addr_we),
    .addr_wval (host_wdata_i[ADDR_W-1:0]),
    .addr_lock (eng_underway),
    .addr_inc  (addr_inc),
    .cfg       (cfg),
    .addr      (addr_q),
    .dsp_rst   (dsp_reset_o)
  );

  dre_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (eng_start),
    .stop       (eng_stop),
    .len        (host_wdata_i[CB_LEN_LO +: 2]),
    .autoinc    (host_wdata_i[CB_AUTO]),
    .space_in   (host_wdata_i[CB_SPACE_LO +: SPACE_W]),
    .fifo_count (fifo_count),
    .mem_gnt    (mem_gnt_i),
    .mem_rvalid (mem_rvalid_i),
    .mem_req    (mem_req_o),
    .mem_space  (mem_space_o),
    .push       (fifo_push),
    .flush      (fifo_flush),
    .addr_inc   (addr_inc),
    .underway   (eng_underway)
  );

  dre_fifo #(.W(REG_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (fifo_flush),
    .push  (fifo_push),
    .din   (mem_rdata_i),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .count (fifo_count)
  );

  assign mem_addr_o = addr_q;
  assign fifo_full  = (fifo_count == CNT_W'(DEPTH));
  assign fifo_ne    = (fifo_count != '0);

  always_comb begin
    status_w              = '0;
    status_w[SB_UNDERWAY] = eng_underway;
    status_w[SB_RST_BUSY] = dsp_reset_o;
    status_w[SB_FULL]     = fifo_full;
    status_w[SB_NE]       = fifo_ne;
  end

  always_comb begin
    cfg_rb                            = '0;
    cfg_rb[CB_RST]                    = cfg.hold_rst;
    cfg_rb[CB_AUTO]                   = cfg.autoinc;
    cfg_rb[CB_LEN_LO +: 2]            = cfg.len;
    cfg_rb[CB_START]                  = eng_underway;
    cfg_rb[CB_IE_FULL]                = cfg.ie_full;
    cfg_rb[CB_IE_NE]                  = cfg.ie_ne;
    cfg_rb[CB_SPACE_LO +: SPACE_W]    = cfg.space;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= SEL_ADDR;
      rdata_q <= '0;
    end else if (host_rd_i) begin
      sel_q <= sel;
      case (sel)
        SEL_ADDR: rdata_q <= REG_W'(addr_q);
        SEL_CFG:  rdata_q <= cfg_rb;
        SEL_STAT: rdata_q <= status_w;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign host_rdata_o = (sel_q == SEL_DATA) ? fifo_dout : rdata_q;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (cfg.ie_full && fifo_full) || (cfg.ie_ne && fifo_ne);
  end

endmodule

// File: rtl/dre_checker.sv
module dre_checker
  import dre_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RST_HOLD = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr_i,
  input logic [1:0]         host_sel_i,
  input logic [REG_W-1:0]   host_wdata_i,
  input logic               irq_o,
  input logic               dsp_reset_o,
  input logic               mem_req_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic [SPACE_W-1:0] mem_space_o,
  input logic               mem_gnt_i,
  input logic               mem_rvalid_i,
  input logic               eng_underway,
  input logic               fifo_full,
  input logic               fifo_ne
);

  logic [7:0] hi_cnt;
  logic       cfg_wr;

  assign cfg_wr = host_wr_i && (host_sel_i == 2'd1);

  always_ff @(posedge clk) begin
    if (rst)              hi_cnt <= '0;
    else if (!dsp_reset_o) hi_cnt <= '0;
    else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 8'd1;
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_gnt_i && !cfg_wr) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_space_o)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !mem_req_o);

  p_push_room_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_rvalid_i && eng_underway) |-> !fifo_full);

  p_stop_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !host_wdata_i[CB_START] && eng_underway) |=> (!eng_underway && !fifo_ne));

  p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(fifo_full || fifo_ne));

  p_rst_width_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(dsp_reset_o) |-> (hi_cnt >= 8'(RST_HOLD)));

endmodule

bind dspmem_rd_engine dre_checker #(.ADDR_W(ADDR_W), .RST_HOLD(RST_HOLD)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_wr_i    (host_wr_i),
  .host_sel_i   (host_sel_i),
  .host_wdata_i (host_wdata_i),
  .irq_o        (irq_o),
  .dsp_reset_o  (dsp_reset_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_space_o  (mem_space_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_rvalid_i (mem_rvalid_i),
  .eng_underway (eng_underway),
  .fifo_full    (fifo_full),
  .fifo_ne      (fifo_ne)
);

// File: tb/dspmem_rd_engine_tb.sv
module dspmem_rd_engine_tb;

  localparam logic [1:0] S_ADDR = 2'd0, S_CFG = 2'd1, S_STAT = 2'd2, S_DATA = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq, dsp_reset, mem_req, mem_gnt = 1'b1;
  logic [15:0] mem_addr;
  logic [3:0]  mem_space;
  logic        p1_v, p2_v;
  logic [15:0] p1_d, p2_d;

  int vectors = 0;
  int miscompares = 0;
  int rst_hi_total = 0;

  always #4 clk = ~clk;

  dspmem_rd_engine u_dut (
    .clk          (clk),
    .rst          (rst),
    .host_wr_i    (host_wr),
    .host_rd_i    (host_rd),
    .host_sel_i   (host_sel),
    .host_wdata_i (host_wdata),
    .host_rdata_o (host_rdata),
    .irq_o        (irq),
    .dsp_reset_o  (dsp_reset),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_space_o  (mem_space),
    .mem_gnt_i    (mem_gnt),
    .mem_rvalid_i (p2_v),
    .mem_rdata_i  (p2_d)
  );

  function automatic logic [15:0] word_at(input logic [15:0] a, input logic [3:0] s);
    return (a ^ 16'hA55A) + {s, 12'h000};
  endfunction

  // memory model: two-cycle read latency, responses in order
  always @(posedge clk) begin
    if (rst) begin
      p1_v <= 1'b0;
      p2_v <= 1'b0;
      p1_d <= '0;
      p2_d <= '0;
    end else begin
      p1_v <= mem_req && mem_gnt;
      p1_d <= word_at(mem_addr, mem_space);
      p2_v <= p1_v;
      p2_d <= p1_d;
    end
  end

  always @(negedge clk) if (dsp_reset) rst_hi_total <= rst_hi_total + 1;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] v);
    @(negedge clk);
    host_rd = 1'b1; host_sel = sel;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 600; i++) begin
      rd(S_STAT, s);
      if (!s[0]) break;
    end
  endtask

  task automatic drain_check(input string tag, input int n, input logic [15:0] a0,
                             input logic step, input logic [3:0] sp);
    logic [15:0] v;
    for (int i = 0; i < n; i++) begin
      rd(S_DATA, v);
      chk(tag, v, word_at(step ? a0 + 16'(i) : a0, sp));
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(S_STAT, v); chk("R1 status", v, 16'h0000);
    rd(S_CFG, v);  chk("R1 control", v, 16'h0000);
    rd(S_ADDR, v); chk("R1 address", v, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 mem_req", {15'b0, mem_req}, 16'h0);
    chk("R1 dsp_reset", {15'b0, dsp_reset}, 16'h0);
  endtask

  task automatic t_single();
    logic [15:0] v;
    wr(S_ADDR, 16'h0040);
    wr(S_CFG, 16'h1012);            // space 1, one word, auto-increment, go
    wait_idle();
    rd(S_STAT, v); chk("R2 one word status", v, 16'h0040);
    chk("R8 irq off when disabled", {15'b0, irq}, 16'h0);
    drain_check("R4 space 1 word", 1, 16'h0040, 1'b1, 4'd1);
    rd(S_ADDR, v); chk("R3 address advanced", v, 16'h0041);
  endtask

  task automatic t_burst8_fixed();
    logic [15:0] v;
    wr(S_ADDR, 16'h1234);
    wr(S_CFG, 16'h0014);            // space 0, eight words, fixed address, go
    wait_idle();
    rd(S_STAT, v); chk("R2 eight words not full", v, 16'h0040);
    drain_check("R3 fixed address", 8, 16'h1234, 1'b0, 4'd0);
    rd(S_STAT, v); chk("R5 empty after drain", v, 16'h0000);
    rd(S_ADDR, v); chk("R3 address unchanged", v, 16'h1234);
    rd(S_DATA, v); chk("R5 empty read returns 0", v, 16'h0000);
    rd(S_STAT, v); chk("R5 empty read no effect", v, 16'h0000);
  endtask

  task automatic t_burst16_full();
    logic [15:0] v;
    wr(S_ADDR, 16'h0200);
    wr(S_CFG, 16'h503A);            // space 5, full irq, sixteen words, auto, go
    wait_idle();
    rd(S_STAT, v); chk("R5 full and not empty", v, 16'h0060);
    chk("R8 irq on full", {15'b0, irq}, 16'h1);
    drain_check("R5 order sixteen", 16, 16'h0200, 1'b1, 4'd5);
    @(negedge clk);
    chk("R8 irq drops when drained", {15'b0, irq}, 16'h0);
    rd(S_ADDR, v); chk("R2 sixteen requests", v, 16'h0210);
  endtask

  task automatic t_irq_ne();
    logic [15:0] v;
    wr(S_ADDR, 16'h0500);
    wr(S_CFG, 16'h0050);            // not-empty irq, one word, go
    wait_idle();
    @(negedge clk);
    chk("R8 irq on not empty", {15'b0, irq}, 16'h1);
    rd(S_DATA, v); chk("R8 word", v, word_at(16'h0500, 4'd0));
    @(negedge clk);
    chk("R8 irq clears", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_freerun();
    logic [15:0] v;
    wr(S_ADDR, 16'h0100);
    wr(S_CFG, 16'h001E);            // continuous, auto, go
    repeat (80) @(negedge clk);
    rd(S_STAT, v); chk("R6 continuous full stall", v, 16'h0061);
    chk("R6 no request when full", {15'b0, mem_req}, 16'h0);
    drain_check("R6 first words", 5, 16'h0100, 1'b1, 4'd0);
    repeat (40) @(negedge clk);
    rd(S_STAT, v); chk("R6 refilled", v, 16'h0061);
    drain_check("R5 order across refill", 3, 16'h0105, 1'b1, 4'd0);
    wr(S_CFG, 16'h000E);            // clear go
    rd(S_STAT, v); chk("R7 stopped and flushed", v, 16'h0000);
    repeat (10) @(negedge clk);
    rd(S_STAT, v); chk("R7 late responses dropped", v, 16'h0000);
    rd(S_DATA, v); chk("R7 data empty", v, 16'h0000);
  endtask

  task automatic t_restart_ignored();
    logic [15:0] v;
    mem_gnt = 1'b0;
    wr(S_ADDR, 16'h0300);
    wr(S_CFG, 16'h001A);            // sixteen words, auto, go
    repeat (4) @(negedge clk);
    chk("R4 request waits for grant", {15'b0, mem_req}, 16'h1);
    chk("R4 request address", mem_addr, 16'h0300);
    wr(S_ADDR, 16'h7777);           // ignored while active
    wr(S_CFG, 16'h0010);            // go again: ignored
    chk("R3 address write ignored", mem_addr, 16'h0300);
    mem_gnt = 1'b1;
    wait_idle();
    rd(S_STAT, v); chk("R10 original burst completes", v, 16'h0060);
    drain_check("R10 original words", 16, 16'h0300, 1'b1, 4'd0);
    rd(S_ADDR, v); chk("R10 address after burst", v, 16'h0310);
  endtask

  task automatic t_dsp_reset();
    logic [15:0] v;
    int base;
    wr(S_ADDR, 16'h0000);
    wr(S_CFG, 16'h001E);
    repeat (30) @(negedge clk);
    base = rst_hi_total;
    wr(S_CFG, 16'h0001);            // reset bit set, ends transfer
    wr(S_CFG, 16'h0000);            // held two cycles only
    rd(S_STAT, v); chk("R9 reset busy, transfer ended", v, 16'h0004);
    chk("R9 dsp_reset high", {15'b0, dsp_reset}, 16'h1);
    repeat (20) @(negedge clk);
    chk("R9 minimum width", 16'(rst_hi_total - base), 16'd8);
    rd(S_STAT, v); chk("R9 busy clears", v, 16'h0000);
    base = rst_hi_total;
    wr(S_CFG, 16'h0001);
    repeat (10) @(negedge clk);
    wr(S_CFG, 16'h0000);            // held twelve cycles
    repeat (20) @(negedge clk);
    chk("R9 long hold width", 16'(rst_hi_total - base), 16'd12);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_burst8_fixed();
    t_burst16_full();
    t_irq_ne();
    t_freerun();
    t_restart_ignored();
    t_dsp_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule